// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block gathers eight interrupt request lines, holds each pending request, and raises one interrupt line toward the processor when an unmasked request outranks all the service levels currently open. Input 0 has the highest priority and input 7 the lowest. When the processor acknowledges, the winning input is moved into service. The block then returns a vector byte, formed from a programmed base and the input number, one cycle later. Software closes a service level with a non-specific end-of-interrupt command, which always closes the highest-priority open level.

Software reaches the block through three byte addresses. Address 0 is the command port. Address 1 carries the configuration sequence and, once that is done, the input mask. Address 2 holds the per-input trigger selection, edge or level. Configuration is a short write sequence. A command-port write with bit 4 set restarts it. The next auxiliary writes then supply the vector base, the cascade word and, if requested, a mode word.

Two instances can be chained. A pin chooses the role. A primary instance treats each input flagged in its cascade word as a link to a secondary instance. When such a link wins, it drives the link's number on the cascade lines during acknowledge and stays silent on the vector. A secondary instance compares the cascade lines with its programmed identity, and it answers the acknowledge only when they match.

The configuration state machine has these states:
- ST_UNINIT: the state after reset.
- ST_BASE: waits for the vector base.
- ST_CASC: waits for the cascade word.
- ST_MODE: waits for the mode word.
- ST_READY: normal operation.

Its transitions are:
- Any state goes to ST_BASE on a command write with bit 4 set.
- ST_BASE goes to ST_CASC on an auxiliary write.
- ST_CASC goes to ST_MODE on an auxiliary write when the mode word was requested. Otherwise it goes to ST_READY.
- ST_MODE goes to ST_READY on an auxiliary write.
- ST_UNINIT and ST_READY keep their state for every other write.

Top module: `pic_ctrl`

## Requirements
- R1: After reset the block is in ST_UNINIT with int_out low. The mask reads 0xFF at address 1, the trigger register reads 0x00 at address 2, nothing is in service, and address 0 reads the request register.
- R2: A write to address 0 with bit 4 set enters ST_BASE from any state. It clears every in-service bit, makes address-0 reads return the request register, and keeps the mask. Its bit 0 set means a mode word follows the cascade word. The next auxiliary writes load the vector base, then the cascade word, then, if requested, the mode word, whose contents are not used. The block is then in ST_READY.
- R3: Auxiliary writes in ST_READY load the mask, where bit i set blocks input i. Auxiliary writes before the first initialization have no effect. int_out stays low in every state except ST_READY.
- R4: For an edge input (trigger bit 0), the request bit is set by a 0-to-1 change seen at a clock edge and stays set until that input is acknowledged. For a level input (trigger bit 1), the request bit follows the input at each clock edge, and acknowledging it does not clear it.
- R5: Address 2 holds the trigger register, one bit per input, and reads back what was written.
- R6: int_out is high exactly when the block is in ST_READY and the lowest-numbered unmasked request has a smaller number than every in-service bit.
- R7: When inta is sampled high at a clock edge and a request wins, the winner's in-service bit is set. For a vector answer, vec_valid is high for the next cycle, with vec_out equal to the upper five bits of the base above the 3-bit input number. An acknowledge with no winning request changes nothing and produces no vector.
- R8: Writing 0x20 to address 0 in ST_READY clears the lowest-numbered set in-service bit. Other writes with bits 4 and 3 clear, such as 0x60, leave the in-service bits unchanged.
- R9: A write to address 0 in ST_READY with bit 4 clear and bit 3 set selects what address 0 returns. Low bits 11 select the in-service register, low bits 10 select the request register, and low bits 00 or 01 keep the current choice.
- R10: In the primary role (role_slave low), when the winner's bit is set in the cascade word, cas_drive is high during inta and cas_out carries the input number. The winner's in-service bit is set, and no vector comes from this instance.
- R11: In the secondary role, the block answers inta only while cas_en_in is high and cas_in equals bits 2..0 of its cascade word. Otherwise its request and in-service bits stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| role_slave | input | 1 | 0 = primary role, 1 = secondary role |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | 0 command, 1 auxiliary, 2 trigger register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq_in | input | NUM_IN | Interrupt request inputs, bit 0 highest priority |
| inta | input | 1 | Acknowledge, sampled at the clock edge |
| cas_en_in | input | 1 | Cascade lines are valid (secondary role) |
| cas_in | input | $clog2(NUM_IN) | Cascade identity from the primary |
| int_out | output | 1 | Interrupt request to the processor or primary |
| cas_drive | output | 1 | Cascade identity driven during inta (primary role) |
| cas_out | output | $clog2(NUM_IN) | Cascade identity of the winning link |
| vec_valid | output | 1 | vec_out valid, for one cycle after acknowledge |
| vec_out | output | 8 | Interrupt vector byte |

## Verification
Single edge requests on one input check vector formation and the clearing of edge requests. Overlapping requests on inputs 5, 3 and 1 arrive while lower levels are in service. They separate correct nesting from a resolver that ignores in-service bits, and an end-of-interrupt that clears the lowest-priority bit from one that clears the highest. A level input held across its end-of-interrupt shows that level requests are not consumed by acknowledge. A chained primary and secondary pair is tried twice, with matching and with mismatching identities, which separates vector ownership in the two roles.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_AUX  = 2'd1;
    localparam logic [ADDR_W-1:0] A_TRIG = 2'd2;

    localparam int CW_INIT_BIT  = 4;   // command word restarts configuration
    localparam int CW_SEL_BIT   = 3;   // 1: read-select word, 0: service command
    localparam int CW_MODE4_BIT = 0;   // mode word follows

    localparam logic [DATA_W-1:0] CMD_NS_EOI = 8'h20;
    localparam logic [1:0] RSEL_IRR = 2'b10;
    localparam logic [1:0] RSEL_ISR = 2'b11;

    typedef enum logic [2:0] {
        ST_UNINIT,
        ST_BASE,
        ST_CASC,
        ST_MODE,
        ST_READY
    } cfg_state_t;
endpackage

// File: rtl/pic_cfg_fsm.sv
module pic_cfg_fsm
    import pic_pkg::*;
#(
    parameter int NUM_IN = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_ctrl,
    input  logic                wr_aux,
    input  logic [DATA_W-1:0]   wdata,
    output cfg_state_t          state,
    output logic                ready,
    output logic                init_pulse,
    output logic                eoi_pulse,
    output logic [DATA_W-1:0]   base,
    output logic [DATA_W-1:0]   casc,
    output logic [NUM_IN-1:0]   mask,
    output logic                read_isr
);
    cfg_state_t state_n;
    logic       want_mode;
    logic       is_sel;
    logic       is_svc;

    assign init_pulse = wr_ctrl && wdata[CW_INIT_BIT];
    assign is_sel     = wr_ctrl && !wdata[CW_INIT_BIT] && wdata[CW_SEL_BIT];
    assign is_svc     = wr_ctrl && !wdata[CW_INIT_BIT] && !wdata[CW_SEL_BIT];
    assign ready      = (state == ST_READY);
    assign eoi_pulse  = ready && is_svc && (wdata == CMD_NS_EOI);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_UNINIT;
        else        state <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state;
        if (init_pulse) begin
            state_n = ST_BASE;
        end else begin
            unique case (state)
                ST_UNINIT: state_n = ST_UNINIT;
                ST_BASE:   if (wr_aux) state_n = ST_CASC;
                ST_CASC:   if (wr_aux) state_n = want_mode ? ST_MODE : ST_READY;
                ST_MODE:   if (wr_aux) state_n = ST_READY;
                ST_READY:  state_n = ST_READY;
                default:   state_n = ST_UNINIT;
            endcase
        end
    end

    // configuration outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            want_mode <= 1'b0;
            base      <= '0;
            casc      <= '0;
            mask      <= '1;
            read_isr  <= 1'b0;
        end else if (init_pulse) begin
            want_mode <= wdata[CW_MODE4_BIT];
            read_isr  <= 1'b0;
        end else begin
            if (wr_aux && state == ST_BASE)  base <= wdata;
            if (wr_aux && state == ST_CASC)  casc <= wdata;
            if (wr_aux && state == ST_READY) mask <= wdata[NUM_IN-1:0];
            if (is_sel && ready) begin
                if (wdata[1:0] == RSEL_ISR)      read_isr <= 1'b1;
                else if (wdata[1:0] == RSEL_IRR) read_isr <= 1'b0;
            end
        end
    end

    assert_init_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[CW_INIT_BIT]) |=> (state == ST_BASE));

    assert_mask_only_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_aux && state == ST_READY) |=> $stable(mask));
endmodule

// File: rtl/pic_request.sv
module pic_request
    import pic_pkg::*;
#(
    parameter int NUM_IN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic              trig_wr,
    input  logic [NUM_IN-1:0] trig_wdata,
    input  logic [NUM_IN-1:0] ack_clr,
    output logic [NUM_IN-1:0] irr,
    output logic [NUM_IN-1:0] trig
);
    logic [NUM_IN-1:0] prev_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_in <= '0;
            trig    <= '0;
        end else begin
            prev_in <= irq_in;
            if (trig_wr) trig <= trig_wdata;
        end
    end

    for (genvar i = 0; i < NUM_IN; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     irr[i] <= 1'b0;
            else if (trig[i])               irr[i] <= irq_in[i];
            else if (irq_in[i] && !prev_in[i]) irr[i] <= 1'b1;
            else if (ack_clr[i])            irr[i] <= 1'b0;
        end
    end

    assert_level_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((irr ^ $past(irq_in)) & $past(trig)) == '0));

    assert_edge_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(irr) & ~$past(trig) & ~$past(ack_clr)) & ~irr) == '0));
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver #(
    parameter int NUM_IN = 8,
    localparam int IDW = $clog2(NUM_IN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [NUM_IN-1:0] irr,
    input  logic [NUM_IN-1:0] mask,
    input  logic [NUM_IN-1:0] isr,
    output logic              int_req,
    output logic [IDW-1:0]    win_idx,
    output logic              isr_any,
    output logic [IDW-1:0]    isr_top
);
    logic [NUM_IN-1:0] live;
    logic              req_any;

    assign live = irr & ~mask;

    always_comb begin
        req_any = 1'b0;
        win_idx = '0;
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (live[i]) begin
                req_any = 1'b1;
                win_idx = IDW'(i);
            end
        end
    end

    always_comb begin
        isr_any = 1'b0;
        isr_top = '0;
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (isr[i]) begin
                isr_any = 1'b1;
                isr_top = IDW'(i);
            end
        end
    end

    assign int_req = enable && req_any && (!isr_any || (win_idx < isr_top));

    assert_winner_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (irr[win_idx] && !mask[win_idx] && !isr[win_idx]));
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
#(
    parameter int NUM_IN = 8,
    localparam int IDW = $clog2(NUM_IN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              role_slave,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic              inta,
    input  logic              cas_en_in,
    input  logic [IDW-1:0]    cas_in,
    output logic              int_out,
    output logic              cas_drive,
    output logic [IDW-1:0]    cas_out,
    output logic              vec_valid,
    output logic [DATA_W-1:0] vec_out
);
    cfg_state_t        state;
    logic              ready, init_pulse, eoi_pulse, read_isr;
    logic [DATA_W-1:0] base, casc;
    logic [NUM_IN-1:0] mask, irr, trig, isr;
    logic [NUM_IN-1:0] ack_clr, eoi_clr;
    logic [IDW-1:0]    win_idx, isr_top;
    logic              int_req, isr_any;
    logic              wr_ctrl, wr_aux, wr_trig;
    logic              id_match, ack_fire, link_win;

    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_aux  = bus_wr && (bus_addr == A_AUX);
    assign wr_trig = bus_wr && (bus_addr == A_TRIG);

    pic_cfg_fsm #(.NUM_IN(NUM_IN)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wr_aux     (wr_aux),
        .wdata      (bus_wdata),
        .state      (state),
        .ready      (ready),
        .init_pulse (init_pulse),
        .eoi_pulse  (eoi_pulse),
        .base       (base),
        .casc       (casc),
        .mask       (mask),
        .read_isr   (read_isr)
    );

    pic_request #(.NUM_IN(NUM_IN)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .trig_wr    (wr_trig),
        .trig_wdata (bus_wdata[NUM_IN-1:0]),
        .ack_clr    (ack_clr),
        .irr        (irr),
        .trig       (trig)
    );

    pic_resolver #(.NUM_IN(NUM_IN)) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (ready),
        .irr     (irr),
        .mask    (mask),
        .isr     (isr),
        .int_req (int_req),
        .win_idx (win_idx),
        .isr_any (isr_any),
        .isr_top (isr_top)
    );

    // acknowledge qualification per role
    assign id_match = cas_en_in && (cas_in == casc[IDW-1:0]);
    assign ack_fire = inta && int_req && (!role_slave || id_match);
    assign link_win = !role_slave && casc[win_idx];
    assign ack_clr  = ack_fire ? (NUM_IN'(1) << win_idx) : '0;
    assign eoi_clr  = (eoi_pulse && isr_any) ? (NUM_IN'(1) << isr_top) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          isr <= '0;
        else if (init_pulse) isr <= '0;
        else                 isr <= (isr & ~eoi_clr) | ack_clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end else begin
            vec_valid <= ack_fire && !link_win;
            if (ack_fire && !link_win) vec_out <= {base[DATA_W-1:IDW], win_idx};
        end
    end

    assign int_out   = int_req;
    assign cas_drive = ack_fire && link_win;
    assign cas_out   = cas_drive ? win_idx : '0;

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = DATA_W'(read_isr ? isr : irr);
            A_AUX:   bus_rdata = DATA_W'(mask);
            A_TRIG:  bus_rdata = DATA_W'(trig);
            default: bus_rdata = '0;
        endcase
    end

    assert_quiet_unless_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_READY) |-> !int_out);

    assert_vector_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && int_out && !role_slave && !cas_drive) |=> vec_valid);

    assert_no_vector_without_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !inta |=> !vec_valid);

    assert_eoi_closes_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_pulse && !ack_fire && isr != '0) |=> ($countones(isr) == $countones($past(isr)) - 1));

    assert_cascade_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cas_drive |-> (inta && !role_slave));

    assert_slave_ignores_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (role_slave && inta && !(cas_en_in && cas_in == casc[IDW-1:0]) && !bus_wr)
        |=> ($stable(isr) && !vec_valid));
endmodule

// File: tb/pic_ctrl_test.sv
module pic_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_wr = 1'b0, p_wr = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] m_irq = '0, p_irq = '0;
    logic       inta = 1'b0;

    wire [7:0] m_rdata, p_rdata, m_vec, p_vec;
    wire       m_int, p_int, m_cd, p_cd, m_vv, p_vv;
    wire [2:0] m_co, p_co;
    wire [7:0] m_lines = {m_irq[7:3], p_int, m_irq[1:0]};

    always #4 clk = ~clk;

    pic_ctrl uut (
        .clk(clk), .rst_n(rst_n), .role_slave(1'b0),
        .bus_wr(m_wr), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(m_rdata),
        .irq_in(m_lines), .inta(inta), .cas_en_in(1'b0), .cas_in(3'd0),
        .int_out(m_int), .cas_drive(m_cd), .cas_out(m_co),
        .vec_valid(m_vv), .vec_out(m_vec)
    );

    pic_ctrl peer (
        .clk(clk), .rst_n(rst_n), .role_slave(1'b1),
        .bus_wr(p_wr), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(p_rdata),
        .irq_in(p_irq), .inta(inta), .cas_en_in(m_cd), .cas_in(m_co),
        .int_out(p_int), .cas_drive(p_cd), .cas_out(p_co),
        .vec_valid(p_vv), .vec_out(p_vec)
    );

    int         total = 0;
    int         bad = 0;
    bit         finished = 0;
    logic [7:0] exp_q[$];
    logic [7:0] got, want;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit who, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a;
        wdata = d;
        if (who) p_wr = 1'b1; else m_wr = 1'b1;
        @(negedge clk);
        m_wr = 1'b0;
        p_wr = 1'b0;
    endtask

    task automatic rd_chk(input bit who, input logic [1:0] a, input logic [7:0] exp, input string tag);
        addr = a;
        #1;
        chk(tag, who ? p_rdata : m_rdata, exp);
    endtask

    // driver: pushes the expected vector, then pulses acknowledge
    task automatic ack(input bit has_vec, input logic [7:0] vec, input bit has_cas,
                       input logic [2:0] cas, input string tag);
        if (has_vec) exp_q.push_back(vec);
        @(negedge clk);
        inta = 1'b1;
        #1;
        chk({tag, " cas_drive"}, {7'd0, m_cd}, {7'd0, has_cas});
        if (has_cas) chk({tag, " cas_out"}, {5'd0, m_co}, {5'd0, cas});
        @(negedge clk);
        inta = 1'b0;
        #1;
        if (!has_vec) chk({tag, " no vector"}, {6'd0, m_vv, p_vv}, 8'h00);
    endtask

    // monitor: compares every produced vector against the queue (R7)
    always @(negedge clk) begin
        if (rst_n && (m_vv || p_vv)) begin
            got = m_vv ? m_vec : p_vec;
            total++;
            if (m_vv && p_vv) begin
                bad++;
                $display("FAIL R10 both instances answered actual=%02h expected=single", got);
            end else if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R7 unexpected vector actual=%02h expected=none", got);
            end else begin
                want = exp_q.pop_front();
                if (got !== want) begin
                    bad++;
                    $display("FAIL R7 vector actual=%02h expected=%02h", got, want);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 int_out", {7'd0, m_int}, 8'h00);
        rd_chk(0, 2'd1, 8'hFF, "R1 mask");
        rd_chk(0, 2'd2, 8'h00, "R1 trigger");
        rd_chk(0, 2'd0, 8'h00, "R1 request");

        // R3 aux write before init ignored; request latched but int_out quiet
        wr(0, 2'd1, 8'h00);
        rd_chk(0, 2'd1, 8'hFF, "R3 mask before init");
        m_irq[0] = 1'b1;
        tick(1);
        rd_chk(0, 2'd0, 8'h01, "R4 edge request");
        chk("R3 quiet before init", {7'd0, m_int}, 8'h00);

        // R2 init with mode word
        wr(0, 2'd0, 8'h11);
        wr(0, 2'd1, 8'h40);
        wr(0, 2'd1, 8'h04);
        wr(0, 2'd1, 8'h01);
        chk("R6 masked input", {7'd0, m_int}, 8'h00);
        wr(0, 2'd1, 8'h00);
        rd_chk(0, 2'd1, 8'h00, "R3 mask load");
        chk("R6 unmasked request", {7'd0, m_int}, 8'h01);
        ack(1, 8'h40, 0, 3'd0, "R7 input0");
        chk("R6 blocked by service", {7'd0, m_int}, 8'h00);
        rd_chk(0, 2'd0, 8'h00, "R4 edge cleared by ack");
        wr(0, 2'd0, 8'h0B);
        rd_chk(0, 2'd0, 8'h01, "R9 isr select");
        m_irq[0] = 1'b0;

        // nesting and end-of-interrupt
        m_irq[5] = 1'b1;
        tick(1);
        chk("R6 lower request held off", {7'd0, m_int}, 8'h00);
        wr(0, 2'd0, 8'h20);
        rd_chk(0, 2'd0, 8'h00, "R8 eoi");
        chk("R6 request after eoi", {7'd0, m_int}, 8'h01);
        m_irq[3] = 1'b1;
        tick(1);
        ack(1, 8'h43, 0, 3'd0, "R6 priority 3 over 5");
        chk("R6 input5 below input3", {7'd0, m_int}, 8'h00);
        m_irq[1] = 1'b1;
        tick(1);
        chk("R6 higher request nests", {7'd0, m_int}, 8'h01);
        ack(1, 8'h41, 0, 3'd0, "R7 input1");
        rd_chk(0, 2'd0, 8'h0A, "R7 isr bits");
        wr(0, 2'd0, 8'h20);
        rd_chk(0, 2'd0, 8'h08, "R8 clears highest priority");
        wr(0, 2'd0, 8'h60);
        rd_chk(0, 2'd0, 8'h08, "R8 other command ignored");
        wr(0, 2'd0, 8'h20);
        chk("R6 input5 now wins", {7'd0, m_int}, 8'h01);
        ack(1, 8'h45, 0, 3'd0, "R7 input5");
        wr(0, 2'd0, 8'h20);
        m_irq[5] = 1'b0;
        m_irq[3] = 1'b0;
        m_irq[1] = 1'b0;
        rd_chk(0, 2'd0, 8'h00, "R8 all closed");

        // level trigger
        wr(0, 2'd2, 8'h80);
        rd_chk(0, 2'd2, 8'h80, "R5 trigger readback");
        m_irq[7] = 1'b1;
        tick(1);
        chk("R4 level request", {7'd0, m_int}, 8'h01);
        ack(1, 8'h47, 0, 3'd0, "R7 input7");
        wr(0, 2'd0, 8'h0A);
        rd_chk(0, 2'd0, 8'h80, "R4 level kept after ack");
        wr(0, 2'd0, 8'h08);
        wr(0, 2'd0, 8'h20);
        rd_chk(0, 2'd0, 8'h80, "R9 select unchanged by 00");
        chk("R4 level re-requests", {7'd0, m_int}, 8'h01);
        m_irq[7] = 1'b0;
        tick(1);
        chk("R4 level released", {7'd0, m_int}, 8'h00);
        rd_chk(0, 2'd0, 8'h00, "R4 level request gone");

        // acknowledge with nothing pending
        ack(0, 8'h00, 0, 3'd0, "R7 spurious");
        wr(0, 2'd0, 8'h0B);
        rd_chk(0, 2'd0, 8'h00, "R7 spurious leaves isr");

        // cascade, secondary without mode word
        wr(1, 2'd0, 8'h10);
        wr(1, 2'd1, 8'h48);
        wr(1, 2'd1, 8'h02);
        wr(1, 2'd1, 8'h00);
        rd_chk(1, 2'd1, 8'h00, "R2 mode word skipped");
        p_irq[4] = 1'b1;
        tick(2);
        chk("R10 link raises primary", {7'd0, m_int}, 8'h01);
        ack(1, 8'h4C, 1, 3'd2, "R10 cascade");
        chk("R11 secondary in service", {7'd0, p_int}, 8'h00);
        rd_chk(0, 2'd0, 8'h04, "R10 link in service");

        // identity mismatch
        wr(0, 2'd0, 8'h20);
        p_irq[4] = 1'b0;
        wr(1, 2'd0, 8'h10);
        wr(1, 2'd1, 8'h48);
        wr(1, 2'd1, 8'h03);
        wr(1, 2'd1, 8'h00);
        p_irq[4] = 1'b1;
        tick(2);
        chk("R10 link raises again", {7'd0, m_int}, 8'h01);
        ack(0, 8'h00, 1, 3'd2, "R11 mismatch");
        chk("R11 request still raised", {7'd0, p_int}, 8'h01);
        rd_chk(1, 2'd0, 8'h10, "R11 request kept");

        // re-initialization clears service, keeps mask
        wr(0, 2'd0, 8'h11);
        wr(0, 2'd1, 8'h40);
        wr(0, 2'd1, 8'h04);
        wr(0, 2'd1, 8'h01);
        rd_chk(0, 2'd1, 8'h00, "R2 mask kept");
        wr(0, 2'd0, 8'h0B);
        rd_chk(0, 2'd0, 8'h00, "R2 service cleared");

        tick(3);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R7 missing vectors actual=%0d expected=0", exp_q.size());
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule